// File: doc/BRIEF.md
# Multi-Algorithm Hash Compression Engine

This block performs one compression step of a 512-bit message block for any of four digest algorithms: SM3, SHA-1, SHA-224 and SHA-256. A caller that has already padded the message presents one block together with an algorithm code and a flag that says whether the block opens a new message. It then pulses `start`. The engine splits the block into sixteen words, runs one round per clock and folds the result into its chaining value. It raises `done` for a single cycle when the new digest is on `digest`.

Multi-block messages are hashed by issuing the blocks one after another. The first carries `first` high and each later one carries it low, so the engine continues from the chaining value it holds. The message schedule is produced while the rounds run, from a sliding window of sixteen words. The round logic is shared between the algorithms rather than duplicated per algorithm. Padding, length counting and keyed hashing belong to the surrounding logic.

Top module: `multi_hash_core`

## Requirements
- R1: `alg` selects the algorithm with the codes 0 = SM3, 1 = SHA-1, 2 = SHA-224, 3 = SHA-256. A block started with `first` = 1 is compressed from that algorithm's standard initial value, and the result equals the known digest of a one-block message.
- R2: A block started with `first` = 0 continues from the chaining value left by the previous block, so two consecutive blocks give the known digest of a two-block message.
- R3: `done` rises exactly 64 clock edges after the edge that accepts `start` for SM3, SHA-224 and SHA-256, and exactly 80 edges after it for SHA-1 (one round per clock).
- R4: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` is high for one cycle only, and `busy` is low in that cycle.
- R5: `digest` is left-justified. SHA-224 fills bits 255:32 and drives bits 31:0 to zero. SHA-1 fills bits 255:96 and drives bits 95:0 to zero. SM3 and SHA-256 use all 256 bits.
- R6: A `start` pulse while `busy` is high is ignored. The running block finishes with its own algorithm, its own latency and its own result.
- R7: While reset is held, `busy`, `done` and `digest` are all zero.
- R8: While the engine is idle and `start` is low, `digest` keeps its value whatever the other inputs do.
- R9: Bits 511:480 of `block` are message word 0 and bits 31:0 are word 15, each word big-endian.
- R10: At the end of a block, SM3 XORs the working variables into the chaining value, and the SHA modes add them modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a block; taken only while idle |
| alg | input | 2 | Algorithm code: 0 SM3, 1 SHA-1, 2 SHA-224, 3 SHA-256 |
| first | input | 1 | 1: start from the standard initial value; 0: continue the held chain |
| block | input | 512 | Padded message block, word 0 in the top bits |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse: digest updated |
| digest | output | 256 | Chaining value, left-justified and masked to the algorithm's width |

## Verification
The engine has no tunable parameters, because the word size, the block size and the round counts are fixed by the algorithms. The bench therefore builds the one configuration that exists. That single build covers all four modes. It exercises both starting points of the chain and the longer 80-round SHA-1 loop beside the 64-round modes. Known-answer digests for a one-block and a two-block message in each mode check the word order, the expansion, the round paths and both kinds of feed-forward. Directed cases check the latency, the handshake, a start pulse arriving mid-block and the idle hold.

// File: rtl/multi_hash_core.sv
module multi_hash_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   alg,
  input  logic         first,
  input  logic [511:0] block,
  output logic         busy,
  output logic         done,
  output logic [255:0] digest
);

  localparam logic [1:0] M_SM3    = 2'd0;
  localparam logic [1:0] M_SHA1   = 2'd1;
  localparam logic [1:0] M_SHA224 = 2'd2;
  localparam logic [1:0] M_SHA256 = 2'd3;
  localparam int WORDS = 16;
  localparam int NVAR  = 8;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] chf(input logic [31:0] x, y, z);
    return (x & y) | (~x & z);
  endfunction
  function automatic logic [31:0] majf(input logic [31:0] x, y, z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic [31:0] iv(input logic [1:0] m, input int i);
    logic [255:0] t;
    case (m)
      M_SM3:    t = 256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
      M_SHA1:   t = {160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0, 96'h0};
      M_SHA224: t = 256'hc1059ed8_367cd507_3070dd17_f70e5939_ffc00b31_68581511_64f98fa7_befa4fa4;
      default:  t = 256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
    endcase
    return t[255-32*i -: 32];
  endfunction

  function automatic logic [31:0] k256(input logic [5:0] i);
    logic [31:0] k;
    case (i)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
    endcase
    return k;
  endfunction

  logic [1:0]  mode;
  logic [6:0]  rnd;
  logic [31:0] cv [NVAR];
  logic [31:0] v  [NVAR];
  logic [31:0] vn [NVAR];
  logic [31:0] w  [WORDS];
  logic [31:0] w_new;

  logic        is_sm3, is_sha1, early;
  logic [6:0]  last_rnd;
  assign is_sm3   = (mode == M_SM3);
  assign is_sha1  = (mode == M_SHA1);
  assign early    = (rnd < 7'd16);
  assign last_rnd = is_sha1 ? 7'd79 : 7'd63;

  // expansion path: next schedule word from the 16-word window
  always_comb begin
    logic [31:0] x;
    x = w[0] ^ w[7] ^ rl(w[13], 15);
    if (is_sm3)
      w_new = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(w[3], 7) ^ w[10];
    else if (is_sha1)
      w_new = rl(w[13] ^ w[8] ^ w[2] ^ w[0], 1);
    else
      w_new = (rr(w[14], 17) ^ rr(w[14], 19) ^ (w[14] >> 10)) + w[9]
            + (rr(w[1], 7) ^ rr(w[1], 18) ^ (w[1] >> 3)) + w[0];
  end

  // boolean path and sum path: one round of the selected algorithm
  always_comb begin
    logic [31:0] fx, gx, kx, s1, s2, p, q;
    vn = v;
    fx = '0; gx = '0; kx = '0; s1 = '0; s2 = '0; p = '0; q = '0;
    if (is_sm3) begin
      fx = early ? (v[0] ^ v[1] ^ v[2]) : majf(v[0], v[1], v[2]);
      gx = early ? (v[4] ^ v[5] ^ v[6]) : chf(v[4], v[5], v[6]);
      kx = early ? 32'h79cc4519 : 32'h7a879d8a;
      s1 = rl(rl(v[0], 12) + v[4] + rl(kx, int'(rnd[4:0])), 7);
      s2 = s1 ^ rl(v[0], 12);
      p  = fx + v[3] + s2 + (w[0] ^ w[4]);
      q  = gx + v[7] + s1 + w[0];
      vn[0] = p;  vn[1] = v[0]; vn[2] = rl(v[1], 9);  vn[3] = v[2];
      vn[4] = q ^ rl(q, 9) ^ rl(q, 17);
      vn[5] = v[4]; vn[6] = rl(v[5], 19); vn[7] = v[6];
    end else if (is_sha1) begin
      if (rnd < 7'd20)      begin fx = chf(v[1], v[2], v[3]);  kx = 32'h5a827999; end
      else if (rnd < 7'd40) begin fx = v[1] ^ v[2] ^ v[3];     kx = 32'h6ed9eba1; end
      else if (rnd < 7'd60) begin fx = majf(v[1], v[2], v[3]); kx = 32'h8f1bbcdc; end
      else                  begin fx = v[1] ^ v[2] ^ v[3];     kx = 32'hca62c1d6; end
      p = rl(v[0], 5) + fx + v[4] + kx + w[0];
      vn[0] = p; vn[1] = v[0]; vn[2] = rl(v[1], 30); vn[3] = v[2]; vn[4] = v[3];
    end else begin
      fx = majf(v[0], v[1], v[2]);
      gx = chf(v[4], v[5], v[6]);
      p  = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) + gx + k256(rnd[5:0]) + w[0];
      q  = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) + fx;
      vn[0] = p + q; vn[1] = v[0]; vn[2] = v[1]; vn[3] = v[2];
      vn[4] = v[3] + p; vn[5] = v[4]; vn[6] = v[5]; vn[7] = v[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_SM3;
      rnd  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      for (int i = 0; i < NVAR; i++) begin cv[i] <= '0; v[i] <= '0; end
      for (int i = 0; i < WORDS; i++) w[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          mode <= alg;
          rnd  <= '0;
          busy <= 1'b1;
          for (int i = 0; i < WORDS; i++) w[i] <= block[511-32*i -: 32];
          for (int i = 0; i < NVAR; i++) begin
            cv[i] <= first ? iv(alg, i) : cv[i];
            v[i]  <= first ? iv(alg, i) : cv[i];
          end
        end
      end else begin
        for (int i = 0; i < WORDS-1; i++) w[i] <= w[i+1];
        w[WORDS-1] <= w_new;
        for (int i = 0; i < NVAR; i++) v[i] <= vn[i];
        rnd <= rnd + 7'd1;
        if (rnd == last_rnd) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int i = 0; i < NVAR; i++) cv[i] <= is_sm3 ? (cv[i] ^ vn[i]) : (cv[i] + vn[i]);
        end
      end
    end
  end

  logic [255:0] mask;
  assign mask = is_sha1 ? {{160{1'b1}}, 96'h0} :
                (mode == M_SHA224) ? {{224{1'b1}}, 32'h0} : {256{1'b1}};
  assign digest = {cv[0], cv[1], cv[2], cv[3], cv[4], cv[5], cv[6], cv[7]} & mask;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_round_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || rnd == $past(rnd) + 7'd1));
  assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd <= (mode == M_SHA1 ? 7'd79 : 7'd63)));
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(digest));

endmodule

// File: tb/test_multi_hash_core.sv
module test_multi_hash_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] alg = 2'd0;
  logic first = 1'b0;
  logic [511:0] block = '0;
  logic busy, done;
  logic [255:0] digest;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  multi_hash_core i_multi_hash_core (
    .clk(clk), .rst_n(rst_n), .start(start), .alg(alg), .first(first),
    .block(block), .busy(busy), .done(done), .digest(digest));

  localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [511:0] BLK_Q1  = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                                      32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                                      32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                                      32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] BLK_Q2  = {480'h0, 32'h000001c0};
  localparam logic [511:0] BLK_D1  = {16{32'h61626364}};
  localparam logic [511:0] BLK_D2  = {32'h80000000, 448'h0, 32'h00000200};

  localparam logic [255:0] SM3_ABC = 256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;
  localparam logic [255:0] SM3_TWO = 256'hdebe9ff9_2275b8a1_38604889_c18e5a4d_6fdb70e5_387e5765_293dcba3_9c0c5732;
  localparam logic [255:0] S1_ABC  = {160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d, 96'h0};
  localparam logic [255:0] S1_TWO  = {160'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1, 96'h0};
  localparam logic [255:0] S224_ABC = {224'h23097d22_3405d822_8642a477_bda255b3_2aadbce4_bda0b3f7_e36c9da7, 32'h0};
  localparam logic [255:0] S224_TWO = {224'h75388b16_512776cc_5dba5da1_fd890150_b0c6455c_b4f58b19_52522525, 32'h0};
  localparam logic [255:0] S256_ABC = 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;
  localparam logic [255:0] S256_TWO = 256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1;

  // {alg, first, check digest, block, expected}
  localparam int NV = 12;
  localparam logic [771:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b1, BLK_ABC, SM3_ABC},
    {2'd0, 1'b1, 1'b0, BLK_D1,  256'h0},
    {2'd0, 1'b0, 1'b1, BLK_D2,  SM3_TWO},
    {2'd1, 1'b1, 1'b1, BLK_ABC, S1_ABC},
    {2'd1, 1'b1, 1'b0, BLK_Q1,  256'h0},
    {2'd1, 1'b0, 1'b1, BLK_Q2,  S1_TWO},
    {2'd2, 1'b1, 1'b1, BLK_ABC, S224_ABC},
    {2'd2, 1'b1, 1'b0, BLK_Q1,  256'h0},
    {2'd2, 1'b0, 1'b1, BLK_Q2,  S224_TWO},
    {2'd3, 1'b1, 1'b1, BLK_ABC, S256_ABC},
    {2'd3, 1'b1, 1'b0, BLK_Q1,  256'h0},
    {2'd3, 1'b0, 1'b1, BLK_Q2,  S256_TWO}
  };

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a negedge; returns the number of edges from acceptance to done
  task automatic run(input logic [1:0] a, input logic f, input logic [511:0] b, output int lat);
    alg = a; first = f; block = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    check("R4 busy after start", 256'(busy), 256'(1));
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R4 busy low with done", 256'(busy), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [255:0] held;
    repeat (3) @(negedge clk);
    check("R7 busy in reset", 256'(busy), 256'(0));
    check("R7 done in reset", 256'(done), 256'(0));
    check("R7 digest in reset", digest, 256'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R9 R10: known-answer table
    for (int n = 0; n < NV; n++) begin
      logic [771:0] e;
      e = VEC[n];
      run(e[771:770], e[769], e[767:256], lat);
      check(e[771:770] == 2'd1 ? "R3 latency sha1" : "R3 latency", 256'(lat),
            256'(e[771:770] == 2'd1 ? 80 : 64));
      if (e[768])
        check(e[769] ? "R1 R9 R10 one-block digest" : "R2 two-block digest", digest, e[255:0]);
      @(negedge clk);
      check("R4 done single cycle", 256'(done), 256'(0));
    end

    // R5: unused low bits are zero
    run(2'd1, 1'b1, BLK_ABC, lat);
    check("R5 sha1 low 96 bits", 256'(digest[95:0]), 256'h0);
    run(2'd2, 1'b1, BLK_ABC, lat);
    check("R5 sha224 low 32 bits", 256'(digest[31:0]), 256'h0);
    check("R5 sha224 top 224 bits", digest, S224_ABC);

    // R6: start while busy is ignored
    alg = 2'd3; first = 1'b1; block = BLK_ABC; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 10) begin alg = 2'd0; block = BLK_D1; start = 1'b1; end
      else start = 1'b0;
    end
    start = 1'b0;
    check("R6 latency unchanged", 256'(lat), 256'(64));
    check("R6 result unchanged", digest, S256_ABC);

    // R8: idle hold with moving inputs
    held = digest;
    for (int n = 0; n < 20; n++) begin
      alg = 2'(n); first = n[0]; block = {16{32'(n * 32'h01010101)}};
      @(negedge clk);
    end
    check("R8 digest held while idle", digest, held);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule